// File: doc/BRIEF.md
# Single-Byte Serial Port with Register Bus

This block is a serial transmitter and receiver that software drives through five word-aligned registers on a simple synchronous bus. The bus has an address, a write strobe, a read strobe and a write-data word. Read data is returned combinationally in the same cycle as the address. Each direction holds one byte. A byte written to the data register waits in a holding buffer until transmission is enabled and the shifter is idle. It then goes out as a frame: one low start bit, eight data bits least significant first, and one high stop bit. The receiver checks each start edge, samples each bit at its centre, and places a good frame in a one-byte receive buffer.

The bit period is a whole number of system clocks taken from the divisor register, and no value below sixteen is used. Lost bytes in either direction are recorded in sticky overrun flags. Four event flags live in an interrupt register that is cleared by writing ones. They drive three interrupt pins: a receive pin, a transmit pin, and one overrun pin shared by both directions, each gated by its own enable bit.

Top module: `byte_uart`

## Requirements
- R1: After reset, STATE (0x04), CTRL (0x08) and INT (0x0C) read 0, BAUDDIV (0x10) reads 16, the serial output is high and all three interrupt pins are low.
- R2: CTRL keeps only its low 6 bits and BAUDDIV keeps only its low 21 bits; the other bits read back as 0.
- R3: A transmitted frame is a low start bit, then data bits 0 to 7 in that order, then a high stop bit. Every bit lasts exactly the effective divisor in clocks, and the line is high when idle.
- R4: A write to DATA (0x00) while STATE bit 0 is 0 stores the byte and sets STATE bit 0. The byte enters the shifter only while CTRL bit 0 is 1. At that moment STATE bit 0 clears and INT bit 0 sets.
- R5: A write to DATA while STATE bit 0 is 1 drops the new byte and sets STATE bit 2 and INT bit 2. The stored byte is the one sent later.
- R6: While CTRL bit 1 is 1, a good frame sets STATE bit 1 and INT bit 1. A read of DATA returns the byte and clears STATE bit 1.
- R7: A good frame that arrives while STATE bit 1 is 1 is dropped and sets STATE bit 3 and INT bit 3. DATA keeps the earlier byte.
- R8: A low pulse on the serial input that is shorter than half a bit period does not start a frame.
- R9: A frame whose stop bit is sampled low is discarded and sets no flag. The next good frame is still received.
- R10: While CTRL bit 1 is 0, incoming frames are ignored.
- R11: Writing ones to INT bits 0 to 3 or to STATE bits 2 and 3 clears those bits. Bits written with 0 keep their value.
- R12: The transmit pin is INT[0] AND CTRL[2]. The receive pin is INT[1] AND CTRL[3]. The overrun pin is (INT[2] AND CTRL[4]) OR (INT[3] AND CTRL[5]).
- R13: A BAUDDIV value below 16 reads back as written, but the bit period used is 16 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Byte address of the register |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe (a read of DATA pops the receive buffer) |
| busWdata | input | BUS_W | Write data |
| busRdata | output | BUS_W | Read data, valid in the same cycle as the address |
| txLine | output | 1 | Serial output |
| rxLine | input | 1 | Serial input |
| irqTx | output | 1 | Transmit interrupt |
| irqRx | output | 1 | Receive interrupt |
| irqOverrun | output | 1 | Combined overrun interrupt |

## Verification
The bench targets the cases where a single buffer must hold on to its content. A second write to a full transmit buffer must not replace the byte already there; a design that replaced it would send the wrong byte. A second frame must not overwrite an unread receive byte; a design that overwrote it would lose the first byte without setting a flag. On the receive side, a short glitch and a frame with a low stop bit are both driven onto the input. A receiver that skipped the mid-start recheck, or the stop-bit check, would report a phantom or corrupt byte. A divisor below the floor is also checked by measuring the start bit, which catches a design that ran faster than sixteen clocks per bit.

// File: rtl/byte_uart_pkg.sv
package byte_uart_pkg;
  localparam int DIV_W      = 21;
  localparam int FRAME_BITS = 8;
  localparam int CTRL_W     = 6;
  localparam int FLAG_W     = 4;
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(16);

  localparam int OFF_DATA  = 'h00;
  localparam int OFF_STATE = 'h04;
  localparam int OFF_CTRL  = 'h08;
  localparam int OFF_INT   = 'h0C;
  localparam int OFF_DIV   = 'h10;

  typedef struct packed {
    logic                  txStart;
    logic [FRAME_BITS-1:0] txByte;
    logic                  rxEnable;
    logic [DIV_W-1:0]      bitDiv;
  } ctrlStrobe_t;

  typedef struct packed {
    logic                  txBusy;
    logic                  rxValid;
    logic [FRAME_BITS-1:0] rxByte;
  } dpStatus_t;
endpackage

// File: rtl/byte_uart_regs.sv
module byte_uart_regs
  import byte_uart_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output ctrlStrobe_t       strobe,
  input  dpStatus_t         status,
  output logic              irqTx,
  output logic              irqRx,
  output logic              irqOverrun
);
  logic [FRAME_BITS-1:0] txBuf, rxBuf;
  logic                  txFull, rxFull, txOv, rxOv;
  logic [CTRL_W-1:0]     ctrlReg;
  logic [FLAG_W-1:0]     intFlags, intSet, intClr;
  logic [DIV_W-1:0]      divReg;

  logic selData, selState, selCtrl, selInt, selDiv;
  assign selData  = busAddr == ADDR_W'(OFF_DATA);
  assign selState = busAddr == ADDR_W'(OFF_STATE);
  assign selCtrl  = busAddr == ADDR_W'(OFF_CTRL);
  assign selInt   = busAddr == ADDR_W'(OFF_INT);
  assign selDiv   = busAddr == ADDR_W'(OFF_DIV);

  logic dataWr, dataRd, stateWr, txStart, rxTake, rxLost;
  assign dataWr  = busWe & selData;
  assign dataRd  = busRe & selData;
  assign stateWr = busWe & selState;
  assign txStart = ctrlReg[0] & txFull & ~status.txBusy;
  assign rxTake  = status.rxValid & ~rxFull;
  assign rxLost  = status.rxValid & rxFull;

  assign intSet = {rxLost, dataWr & txFull, rxTake, txStart};
  assign intClr = (busWe & selInt) ? busWdata[FLAG_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf    <= '0;
      rxBuf    <= '0;
      txFull   <= 1'b0;
      rxFull   <= 1'b0;
      txOv     <= 1'b0;
      rxOv     <= 1'b0;
      ctrlReg  <= '0;
      intFlags <= '0;
      divReg   <= MIN_DIV;
    end else begin
      if (txStart) txFull <= 1'b0;
      if (dataWr && !txFull) begin
        txFull <= 1'b1;
        txBuf  <= busWdata[FRAME_BITS-1:0];
      end
      if (dataRd) rxFull <= 1'b0;
      if (rxTake) begin
        rxFull <= 1'b1;
        rxBuf  <= status.rxByte;
      end
      if (stateWr && busWdata[2]) txOv <= 1'b0;
      if (dataWr && txFull) txOv <= 1'b1;
      if (stateWr && busWdata[3]) rxOv <= 1'b0;
      if (rxLost) rxOv <= 1'b1;
      intFlags <= (intFlags & ~intClr) | intSet;
      if (busWe && selCtrl) ctrlReg <= busWdata[CTRL_W-1:0];
      if (busWe && selDiv)  divReg  <= busWdata[DIV_W-1:0];
    end
  end

  always_comb begin
    busRdata = '0;
    if (selData)  busRdata = BUS_W'(rxBuf);
    if (selState) busRdata = BUS_W'({rxOv, txOv, rxFull, txFull});
    if (selCtrl)  busRdata = BUS_W'(ctrlReg);
    if (selInt)   busRdata = BUS_W'(intFlags);
    if (selDiv)   busRdata = BUS_W'(divReg);
  end

  assign strobe.txStart  = txStart;
  assign strobe.txByte   = txBuf;
  assign strobe.rxEnable = ctrlReg[1];
  assign strobe.bitDiv   = (divReg < MIN_DIV) ? MIN_DIV : divReg;

  assign irqTx      = intFlags[0] & ctrlReg[2];
  assign irqRx      = intFlags[1] & ctrlReg[3];
  assign irqOverrun = (intFlags[2] & ctrlReg[4]) | (intFlags[3] & ctrlReg[5]);

  // R5
  txOverrunSet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && txFull) |=> (txOv && intFlags[2]));

  // R4
  txLaunchEnabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status.txBusy) |-> $past(ctrlReg[0]));

  // R6
  rxCapture_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxTake |=> (rxFull && rxBuf == $past(status.rxByte)));
endmodule

// File: rtl/byte_uart_datapath.sv
module byte_uart_datapath
  import byte_uart_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        rxLine,
  output dpStatus_t   status,
  output logic        txLine
);
  localparam int TX_BITS = FRAME_BITS + 2;
  localparam int TXC_W   = $clog2(TX_BITS);
  localparam int RXC_W   = $clog2(FRAME_BITS);

  logic [DIV_W-1:0] lastTick, halfTick;
  assign lastTick = strobe.bitDiv - DIV_W'(1);
  assign halfTick = (strobe.bitDiv >> 1) - DIV_W'(1);

  // transmit shifter
  logic [TX_BITS-1:0] txShift;
  logic [DIV_W-1:0]   txCnt;
  logic [TXC_W-1:0]   txBit;
  logic               txBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1;
      txCnt   <= '0;
      txBit   <= '0;
      txBusy  <= 1'b0;
    end else if (!txBusy) begin
      if (strobe.txStart) begin
        txShift <= {1'b1, strobe.txByte, 1'b0};
        txCnt   <= '0;
        txBit   <= '0;
        txBusy  <= 1'b1;
      end
    end else if (txCnt >= lastTick) begin
      txCnt   <= '0;
      txShift <= {1'b1, txShift[TX_BITS-1:1]};
      if (txBit == TXC_W'(TX_BITS - 1)) txBusy <= 1'b0;
      else txBit <= txBit + TXC_W'(1);
    end else begin
      txCnt <= txCnt + DIV_W'(1);
    end
  end

  assign txLine = txBusy ? txShift[0] : 1'b1;

  // receive deserialiser
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxState_t;
  rxState_t              rxState;
  logic                  rxS1, rxS2, rxPrev, rxValid;
  logic [DIV_W-1:0]      rxCnt;
  logic [RXC_W-1:0]      rxBit;
  logic [FRAME_BITS-1:0] rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxS1    <= 1'b1;
      rxS2    <= 1'b1;
      rxPrev  <= 1'b1;
      rxState <= RX_IDLE;
      rxCnt   <= '0;
      rxBit   <= '0;
      rxShift <= '0;
      rxValid <= 1'b0;
    end else begin
      rxS1    <= rxLine;
      rxS2    <= rxS1;
      rxPrev  <= rxS2;
      rxValid <= 1'b0;
      if (!strobe.rxEnable) begin
        rxState <= RX_IDLE;
      end else begin
        unique case (rxState)
          RX_IDLE: if (rxPrev && !rxS2) begin
            rxState <= RX_START;
            rxCnt   <= '0;
          end
          RX_START: if (rxCnt >= halfTick) begin
            rxCnt   <= '0;
            rxBit   <= '0;
            rxState <= rxS2 ? RX_IDLE : RX_DATA;
          end else rxCnt <= rxCnt + DIV_W'(1);
          RX_DATA: if (rxCnt >= lastTick) begin
            rxCnt   <= '0;
            rxShift <= {rxS2, rxShift[FRAME_BITS-1:1]};
            if (rxBit == RXC_W'(FRAME_BITS - 1)) rxState <= RX_STOP;
            else rxBit <= rxBit + RXC_W'(1);
          end else rxCnt <= rxCnt + DIV_W'(1);
          RX_STOP: if (rxCnt >= lastTick) begin
            rxCnt   <= '0;
            rxValid <= rxS2;
            rxState <= RX_IDLE;
          end else rxCnt <= rxCnt + DIV_W'(1);
          default: rxState <= RX_IDLE;
        endcase
      end
    end
  end

  assign status.txBusy  = txBusy;
  assign status.rxValid = rxValid;
  assign status.rxByte  = rxShift;

  // R3
  startBitLow_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> !txLine);

  // R9
  stopHigh_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(rxS2));

  // R13
  divFloor_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bitDiv >= MIN_DIV);
endmodule

// File: rtl/byte_uart.sv
module byte_uart
  import byte_uart_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic              txLine,
  input  logic              rxLine,
  output logic              irqTx,
  output logic              irqRx,
  output logic              irqOverrun
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;

  byte_uart_regs #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) regsInst (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .strobe(strobe), .status(status),
    .irqTx(irqTx), .irqRx(irqRx), .irqOverrun(irqOverrun)
  );

  byte_uart_datapath dpInst (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxLine(rxLine),
    .status(status), .txLine(txLine)
  );
endmodule

// File: tb/byte_uart_test.sv
module byte_uart_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWe = 1'b0, busRe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        txLine, rxLine, irqTx, irqRx, irqOverrun;
  logic        injMode = 1'b0, injLine = 1'b1;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  assign rxLine = injMode ? injLine : txLine;
  always #2.5 clk = ~clk;

  byte_uart uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .txLine(txLine), .rxLine(rxLine),
    .irqTx(irqTx), .irqRx(irqRx), .irqOverrun(irqOverrun)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bench model of the interrupt pins: {overrun, rx, tx}
  function automatic logic [2:0] expIrq(input logic [31:0] c, input logic [31:0] f);
    return {(f[2] & c[4]) | (f[3] & c[5]), f[1] & c[3], f[0] & c[2]};
  endfunction

  task automatic decodeTx(input int div, output logic [7:0] b, output logic stopBit);
    while (txLine) @(negedge clk);
    waitClk(div / 2);
    for (int i = 0; i < 8; i++) begin
      waitClk(div);
      b[i] = txLine;
    end
    waitClk(div);
    stopBit = txLine;
    waitClk(div);
  endtask

  task automatic sendFrame(input logic [7:0] b, input logic stopBit, input int div);
    @(negedge clk);
    injLine = 1'b0; waitClk(div);
    for (int i = 0; i < 8; i++) begin
      injLine = b[i]; waitClk(div);
    end
    injLine = stopBit; waitClk(div);
    injLine = 1'b1; waitClk(2 * div);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  b, b1, b2;
    logic        sb;
    int          n, div;
    void'($urandom(32'h5EED));
    waitClk(3);
    rstN = 1'b1;
    waitClk(2);

    // R1 reset values
    rd(5'h04, d); chk("R1 state", d, 0);
    rd(5'h08, d); chk("R1 ctrl", d, 0);
    rd(5'h0C, d); chk("R1 int", d, 0);
    rd(5'h10, d); chk("R1 div", d, 16);
    chk("R1 pins", {txLine, irqTx, irqRx, irqOverrun}, 4'b1000);

    // R2 field widths
    wr(5'h08, 32'hFFFF_FFC0); rd(5'h08, d); chk("R2 ctrl upper", d, 0);
    wr(5'h08, 32'h0000_003F); rd(5'h08, d); chk("R2 ctrl low", d, 32'h3F);
    wr(5'h08, 0);
    wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, d); chk("R2 div mask", d, 32'h1F_FFFF);

    // R13 divisor floor: start bit of 0xFF is 16 clocks long
    wr(5'h10, 5); rd(5'h10, d); chk("R13 readback", d, 5);
    wr(5'h08, 1);
    fork
      begin
        while (txLine) @(negedge clk);
        n = 0;
        while (!txLine) begin n++; @(negedge clk); end
      end
      wr(5'h00, 32'hFF);
    join
    chk("R13 start length", n, 16);
    waitClk(200);

    // R3 frame shape at divisor 20, receiver off (R10)
    wr(5'h0C, 32'hF);
    wr(5'h10, 20);
    fork
      decodeTx(20, b, sb);
      wr(5'h00, 32'hA5);
    join
    chk("R3 data", b, 8'hA5);
    chk("R3 stop", sb, 1'b1);
    chk("R3 idle high", txLine, 1'b1);
    rd(5'h04, d); chk("R10 rx ignored", d[1], 1'b0);

    // R4 / R5 held byte, overrun on second write
    wr(5'h0C, 32'hF);
    wr(5'h08, 0);
    wr(5'h00, 32'h3C);
    rd(5'h04, d); chk("R4 full set", d, 32'h1);
    waitClk(30);
    rd(5'h0C, d); chk("R4 no launch when disabled", d, 0);
    chk("R4 line idle", txLine, 1'b1);
    wr(5'h00, 32'h11);
    rd(5'h04, d); chk("R5 state", d, 32'h5);
    rd(5'h0C, d); chk("R5 int", d, 32'h4);
    fork
      decodeTx(20, b, sb);
      wr(5'h08, 1);
    join
    chk("R5 kept byte", b, 8'h3C);
    rd(5'h04, d); chk("R4 full cleared", d, 32'h4);
    rd(5'h0C, d); chk("R4 tx flag", d, 32'h5);

    // R11 write-one-to-clear
    wr(5'h0C, 32'h4); rd(5'h0C, d); chk("R11 int partial", d, 32'h1);
    wr(5'h04, 32'h4); rd(5'h04, d); chk("R11 state", d, 0);
    wr(5'h0C, 32'h1); rd(5'h0C, d); chk("R11 int all", d, 0);

    // R6 random loopback bytes at random divisors
    wr(5'h08, 32'h3);
    for (int k = 0; k < 8; k++) begin
      div = 16 + int'($urandom % 16);
      b = 8'($urandom);
      wr(5'h10, div);
      wr(5'h00, {24'h0, b});
      waitClk(11 * div + 10);
      rd(5'h04, d); chk("R6 rx full", d, 32'h2);
      rd(5'h0C, d); chk("R6 rx flag", d[1], 1'b1);
      rd(5'h00, d); chk("R6 data", d, {24'h0, b});
      rd(5'h04, d); chk("R6 cleared", d, 0);
      wr(5'h0C, 32'hF);
    end

    // R7 receive overrun
    wr(5'h10, 16);
    b1 = 8'h6E; b2 = 8'h91;
    wr(5'h00, {24'h0, b1}); waitClk(200);
    wr(5'h00, {24'h0, b2}); waitClk(200);
    rd(5'h04, d); chk("R7 state", d, 32'hA);
    rd(5'h0C, d); chk("R7 int", d & 32'hA, 32'hA);

    // R12 interrupt gating with all four flags set (tx overrun added)
    wr(5'h08, 0);
    wr(5'h00, 32'h01); wr(5'h00, 32'h02);
    for (int k = 0; k < 12; k++) begin
      logic [31:0] c, f;
      c = ($urandom & 32'h3C);
      if (k == 0) c = 32'h10;
      if (k == 1) c = 32'h20;
      wr(5'h08, c);
      rd(5'h0C, f);
      chk("R12 pins", {29'h0, irqOverrun, irqRx, irqTx}, {29'h0, expIrq(c, f)});
    end
    rd(5'h00, d); chk("R7 first byte kept", d, {24'h0, b1});

    // flush and clear
    wr(5'h08, 1); waitClk(200);
    wr(5'h0C, 32'hF); wr(5'h04, 32'hC);
    rd(5'h0C, d); chk("R11 clear all", d, 0);

    // R8 glitch rejection at divisor 32
    injMode = 1'b1;
    wr(5'h10, 32);
    wr(5'h08, 32'h2);
    @(negedge clk); injLine = 1'b0; waitClk(3); injLine = 1'b1;
    waitClk(400);
    rd(5'h04, d); chk("R8 glitch", d, 0);

    // R9 low stop bit discarded, then recovery
    sendFrame(8'h5A, 1'b0, 32);
    rd(5'h04, d); chk("R9 no byte", d, 0);
    rd(5'h0C, d); chk("R9 no flag", d, 0);
    sendFrame(8'hC3, 1'b1, 32);
    rd(5'h04, d); chk("R9 recovery", d, 32'h2);
    rd(5'h00, d); chk("R9 recovery data", d, 32'hC3);

    // R10 receiver disabled
    wr(5'h0C, 32'hF);
    wr(5'h08, 0);
    sendFrame(8'h77, 1'b1, 32);
    rd(5'h04, d); chk("R10 disabled", d, 0);
    rd(5'h0C, d); chk("R10 no flag", d, 0);

    finishRun();
  end
endmodule